// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block keeps one pending flag per interrupt source. It holds software-programmed enable bits, 4-bit priority levels and a fast-route selector. It presents at most one outstanding request to a processor at any time.

A request is taken directly from a source that sets while the arbiter is idle. After that the arbiter holds that single request until the processor acknowledges it. An acknowledge triggers a full rescan of the pending flags. The highest-priority pending source becomes the next request, provided it is enabled. Trigger detection sits outside the block: a trigger stage pulses a per-source set or clear line and tells the block which sources are edge-triggered.

A request is a 12-bit word. The upper four bits are the source's priority and the lower eight bits are the source number. The word appears either on the normal request output or, for one programmable source, on a separate fast request output. Sources map onto priority registers in groups of `SRC_PER_PRI` consecutive numbers, so neighbouring sources share one priority value. A small byte-addressed register port gives access to the enable bytes, the priority registers and a 16-bit fast-route register.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset both request outputs are zero, and the read data is zero. Every enable bit, priority register and fast-route field reads back zero.
- R2: Source n is enabled by bit (n mod 8) of the enable byte at address EN_BASE + n/8. A set pulse on a disabled source makes it pending but issues no request.
- R3: With nothing outstanding, a set pulse on a source is handled as follows. If the source is enabled and its number is not 0, it becomes the outstanding request one cycle later. When several such sources set in one cycle, the lowest number wins. Source 0 is never issued. While a request is outstanding, set pulses only mark sources pending, and the outstanding word holds steady until an acknowledge or a withdrawal.
- R4: The request word is {priority[3:0], source[7:0]}. The priority comes from the 4-bit register at address PRI_BASE + n/SRC_PER_PRI, which is written from data bits 3:0. The priority is captured when the request is issued.
- R5: The fast-route register is a 16-bit register at FAST_ADDR. Bits 7:0 select a source and bit 15 enables routing. Other bits read zero. A request issued while routing is enabled for its source appears on fast_req, and norm_req then stays zero. The route is fixed at issue time. The two outputs are never nonzero together.
- R6: An acknowledge while a request is outstanding retires that request. If the retired source is edge-triggered (src_edge=1), its pending flag is cleared. A level-triggered source stays pending. An acknowledge with nothing outstanding has no effect.
- R7: One cycle after an acknowledge, the new outstanding request is chosen from the pending sources. The winner is the source with strictly greatest nonzero priority, and on a tie the lowest number wins. Priority-0 sources are never chosen. If the winner is disabled or is source 0, nothing becomes outstanding.
- R8: reg_size selects the access width: 0 for a byte, 1 for 16 bits. The fast-route register needs size 1, and every other register needs size 0. A read of the wrong size, or of an unmapped address, returns 16'hFFFF. A write of the wrong size is ignored. Read data appears one cycle after reg_rd and holds until the next read. A read in the same cycle as a write returns the old value.
- R9: A src_clr pulse clears a source's pending flag. A set pulse on the same source in the same cycle wins. If the cleared source is the outstanding, level-triggered one, and no acknowledge comes in that cycle, the request is withdrawn one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | NUM_SRC | Per-source pulse marking the source pending |
| src_clr | input | NUM_SRC | Per-source pulse clearing the pending flag |
| src_edge | input | NUM_SRC | Per-source trigger type, 1 = edge, 0 = level |
| ack | input | 1 | Processor acknowledge of the outstanding request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_size | input | 1 | Access width, 0 = byte, 1 = 16 bits |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| norm_req | output | 12 | Normal request word, zero when none |
| fast_req | output | 12 | Fast request word, zero when none |

## Verification
The bench builds the arbiter with 64 sources and two sources per priority register. With these values the priority tree is six levels deep and priority ties between neighbouring sources happen often. Random stimulus then reaches the cases of a disabled winner, an acknowledge landing together with clears, and the fast-route source being re-pointed while a request is held. Every fourth source is level-triggered, so the withdraw path and the re-pick path after acknowledge both occur in the random traffic as well as in directed steps.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PRI_W       = 4;
    localparam int SRC_FIELD_W = 8;
    localparam int REQ_W       = PRI_W + SRC_FIELD_W;
    localparam int DATA_W      = 16;
    localparam logic [DATA_W-1:0] BAD_ACCESS = '1;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_HALF = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic                   vld;
        logic                   fast;
        logic [PRI_W-1:0]       pri;
        logic [SRC_FIELD_W-1:0] src;
    } held_req_t;

    function automatic logic [REQ_W-1:0] req_word(held_req_t r);
        return {r.pri, r.src};
    endfunction
endpackage

// File: rtl/irq_arb_scan.sv
// Combinational priority tree: strictly greater priority wins, the lower
// index wins a tie, a zero priority never wins.
module irq_arb_scan
    import irq_arb_pkg::*;
#(
    parameter int N = 256,
    localparam int IW = $clog2(N),
    localparam int LV = $clog2(N)
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][PRI_W-1:0] pri,
    output logic                    found,
    output logic [IW-1:0]           win_idx,
    output logic [PRI_W-1:0]        win_pri
);
    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        localparam int W = N >> l;
        logic [W-1:0][PRI_W-1:0] p;
        logic [W-1:0][IW-1:0]    x;
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < W; k++) begin : g_k
                assign p[k] = cand[k] ? pri[k] : '0;
                assign x[k] = IW'(k);
            end
        end else begin : g_node
            for (genvar k = 0; k < W; k++) begin : g_k
                logic [PRI_W-1:0] pl, ph;
                logic [IW-1:0]    xl, xh;
                logic             take_hi;
                assign pl      = g_lvl[l-1].p[2*k];
                assign ph      = g_lvl[l-1].p[2*k+1];
                assign xl      = g_lvl[l-1].x[2*k];
                assign xh      = g_lvl[l-1].x[2*k+1];
                assign take_hi = ph > pl;
                assign p[k]    = take_hi ? ph : pl;
                assign x[k]    = take_hi ? xh : xl;
            end
        end
    end

    assign win_pri = g_lvl[LV].p[0];
    assign win_idx = g_lvl[LV].x[0];
    assign found   = g_lvl[LV].p[0] != '0;
endmodule

// File: rtl/irq_arb_regs.sv
// Enable bytes, priority registers, fast-route register and read port.
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int          NUM_SRC     = 256,
    parameter int          SRC_PER_PRI = 2,
    parameter int          ADDR_W      = 8,
    parameter int unsigned EN_BASE     = 32'h00,
    parameter int unsigned PRI_BASE    = 32'h40,
    parameter int unsigned FAST_ADDR   = 32'hFE,
    localparam int EN_BYTES = NUM_SRC / 8,
    localparam int NUM_PRI  = NUM_SRC / SRC_PER_PRI
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic                      rd,
    input  logic                      size,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_SRC-1:0]        en_vec,
    output logic [NUM_PRI-1:0][PRI_W-1:0] pri_regs,
    output logic                      fast_on,
    output logic [SRC_FIELD_W-1:0]    fast_sel
);
    localparam int EB_W = $clog2(EN_BYTES);
    localparam int PB_W = $clog2(NUM_PRI);

    typedef struct packed {
        logic [EN_BYTES-1:0][7:0]     en;
        logic [NUM_PRI-1:0][PRI_W-1:0] pri;
        logic                         fast_on;
        logic [SRC_FIELD_W-1:0]       fast_sel;
        logic [DATA_W-1:0]            rdata;
    } regs_t;

    regs_t       r_d, r_q;
    logic [31:0] a32, en_off, pri_off;
    logic        en_hit, pri_hit, fast_hit, is_byte, is_half;
    logic [EB_W-1:0] en_idx;
    logic [PB_W-1:0] pri_idx;

    always_comb begin
        a32      = 32'(addr);
        en_off   = a32 - EN_BASE;
        pri_off  = a32 - PRI_BASE;
        fast_hit = a32 == FAST_ADDR;
        en_hit   = !fast_hit && (en_off < 32'(EN_BYTES));
        pri_hit  = !fast_hit && !en_hit && (pri_off < 32'(NUM_PRI));
        en_idx   = en_off[EB_W-1:0];
        pri_idx  = pri_off[PB_W-1:0];
        is_byte  = size == ACC_BYTE;
        is_half  = size == ACC_HALF;

        r_d = r_q;
        if (rd) begin
            r_d.rdata = BAD_ACCESS;
            if (fast_hit) begin
                if (is_half) r_d.rdata = {r_q.fast_on, 7'b0, r_q.fast_sel};
            end else if (is_byte) begin
                if (en_hit)       r_d.rdata = {8'h00, r_q.en[en_idx]};
                else if (pri_hit) r_d.rdata = {{(DATA_W-PRI_W){1'b0}}, r_q.pri[pri_idx]};
            end
        end
        if (wr) begin
            if (fast_hit) begin
                if (is_half) begin
                    r_d.fast_on  = wdata[15];
                    r_d.fast_sel = wdata[SRC_FIELD_W-1:0];
                end
            end else if (is_byte) begin
                if (en_hit)       r_d.en[en_idx]   = wdata[7:0];
                else if (pri_hit) r_d.pri[pri_idx] = wdata[PRI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata    = r_q.rdata;
    assign en_vec   = r_q.en;
    assign pri_regs = r_q.pri;
    assign fast_on  = r_q.fast_on;
    assign fast_sel = r_q.fast_sel;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int          NUM_SRC     = 256,
    parameter int          SRC_PER_PRI = 2,
    parameter int          ADDR_W      = 8,
    parameter int unsigned EN_BASE     = 32'h00,
    parameter int unsigned PRI_BASE    = 32'h40,
    parameter int unsigned FAST_ADDR   = 32'hFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic [NUM_SRC-1:0] src_edge,
    input  logic               ack,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_size,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic [11:0]        norm_req,
    output logic [11:0]        fast_req
);
    localparam int IW      = $clog2(NUM_SRC);
    localparam int NUM_PRI = NUM_SRC / SRC_PER_PRI;
    localparam logic [NUM_SRC-1:0][PRI_W-1:0] FLAT_PRI = '1;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        held_req_t          hold;
    } arb_t;

    arb_t s_d, s_q;

    logic [NUM_SRC-1:0]            en_vec;
    logic [NUM_PRI-1:0][PRI_W-1:0] pri_regs;
    logic [NUM_SRC-1:0][PRI_W-1:0] src_pri;
    logic                          fast_on;
    logic [SRC_FIELD_W-1:0]        fast_sel;

    irq_arb_regs #(
        .NUM_SRC(NUM_SRC), .SRC_PER_PRI(SRC_PER_PRI), .ADDR_W(ADDR_W),
        .EN_BASE(EN_BASE), .PRI_BASE(PRI_BASE), .FAST_ADDR(FAST_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .size(reg_size),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .en_vec(en_vec), .pri_regs(pri_regs), .fast_on(fast_on), .fast_sel(fast_sel)
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign src_pri[n] = pri_regs[n / SRC_PER_PRI];
    end

    logic [IW-1:0]      hold_idx;
    logic               ack_fire;
    logic [NUM_SRC-1:0] ack_mask, scan_vec, new_vec;
    logic               rs_found, ns_found;
    logic [IW-1:0]      rs_idx, ns_idx;
    logic [PRI_W-1:0]   rs_pri, ns_pri_unused;

    assign hold_idx = s_q.hold.src[IW-1:0];
    assign ack_fire = ack && s_q.hold.vld;
    assign ack_mask = (ack_fire && src_edge[hold_idx]) ? (NUM_SRC'(1) << hold_idx) : '0;
    assign scan_vec = s_q.pend & ~ack_mask;
    assign new_vec  = src_set & en_vec & ~NUM_SRC'(1);

    // rescan after acknowledge
    irq_arb_scan #(.N(NUM_SRC)) u_rescan (
        .cand(scan_vec), .pri(src_pri),
        .found(rs_found), .win_idx(rs_idx), .win_pri(rs_pri)
    );

    // lowest-numbered newly set source: equal weights make the tie rule pick it
    irq_arb_scan #(.N(NUM_SRC)) u_newpick (
        .cand(new_vec), .pri(FLAT_PRI),
        .found(ns_found), .win_idx(ns_idx), .win_pri(ns_pri_unused)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pend = (s_q.pend & ~ack_mask & ~src_clr) | src_set;
        if (ack_fire) begin
            s_d.hold = '0;
            if (rs_found && rs_idx != '0 && en_vec[rs_idx]) begin
                s_d.hold.vld  = 1'b1;
                s_d.hold.fast = fast_on && (fast_sel == SRC_FIELD_W'(rs_idx));
                s_d.hold.pri  = rs_pri;
                s_d.hold.src  = SRC_FIELD_W'(rs_idx);
            end
        end else if (s_q.hold.vld) begin
            if (src_clr[hold_idx] && !src_edge[hold_idx] && !src_set[hold_idx])
                s_d.hold = '0;
        end else if (ns_found) begin
            s_d.hold.vld  = 1'b1;
            s_d.hold.fast = fast_on && (fast_sel == SRC_FIELD_W'(ns_idx));
            s_d.hold.pri  = src_pri[ns_idx];
            s_d.hold.src  = SRC_FIELD_W'(ns_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign norm_req = (s_q.hold.vld && !s_q.hold.fast) ? req_word(s_q.hold) : '0;
    assign fast_req = (s_q.hold.vld &&  s_q.hold.fast) ? req_word(s_q.hold) : '0;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int          NUM_SRC   = 256,
    parameter int          ADDR_W    = 8,
    parameter int unsigned FAST_ADDR = 32'hFE
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_set,
    input logic [NUM_SRC-1:0] src_clr,
    input logic               ack,
    input logic               reg_rd,
    input logic               reg_size,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [15:0]        reg_rdata,
    input logic [11:0]        norm_req,
    input logic [11:0]        fast_req
);
    assert_one_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_req == '0) || (fast_req == '0));

    assert_hold_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((norm_req != '0 || fast_req != '0) && !ack && src_clr == '0)
        |=> ($stable(norm_req) && $stable(fast_req)));

    assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_req == '0 && fast_req == '0 && src_set == '0)
        |=> (norm_req == '0 && fast_req == '0));

    assert_src_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_req != '0 || fast_req != '0) |-> ((norm_req[7:0] | fast_req[7:0]) != 8'h00));

    assert_fast_byte_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(FAST_ADDR) && !reg_size) |=> (reg_rdata == 16'hFFFF));
endmodule

bind irq_prio_arbiter irq_arb_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .FAST_ADDR(FAST_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr), .ack(ack),
    .reg_rd(reg_rd), .reg_size(reg_size), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .norm_req(norm_req), .fast_req(fast_req)
);

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
    localparam int NS = 64;
    localparam logic [NS-1:0] EDGE_CFG = 64'hEEEE_EEEE_EEEE_EEEE; // n%4==0 is level

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_set = '0, src_clr = '0;
    logic [NS-1:0] src_edge;
    logic          ack = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, reg_size = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [11:0]   norm_req, fast_req;

    assign src_edge = EDGE_CFG;
    always #2 clk = ~clk;

    irq_prio_arbiter #(.NUM_SRC(NS), .SRC_PER_PRI(2)) dut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .src_edge(src_edge), .ack(ack), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .norm_req(norm_req), .fast_req(fast_req)
    );

    int checks = 0, fails = 0;

    // reference model state
    logic [NS-1:0] m_en = '0, m_pend = '0;
    logic [3:0]    m_pri [32];
    logic          m_fast_on = 1'b0;
    logic [7:0]    m_fast_sel = '0;
    logic [15:0]   m_rdata = '0;
    logic          m_vld = 1'b0, m_fast = 1'b0;
    logic [3:0]    m_p = '0;
    logic [7:0]    m_s = '0;

    function automatic logic [3:0] pri_of(int n);
        return m_pri[n / 2];
    endfunction

    function automatic logic [15:0] exp_read(logic [7:0] a, logic s);
        if (a == 8'hFE) return s ? {m_fast_on, 7'b0, m_fast_sel} : 16'hFFFF;
        if (s) return 16'hFFFF;
        if (a < 8'd8) return {8'h00, m_en[int'(a)*8 +: 8]};
        if (a >= 8'h40 && a < 8'h60) return {12'h000, m_pri[int'(a - 8'h40)]};
        return 16'hFFFF;
    endfunction

    task automatic issue(int n);
        m_vld  = 1'b1;
        m_fast = m_fast_on && (m_fast_sel == 8'(n));
        m_p    = pri_of(n);
        m_s    = 8'(n);
    endtask

    task automatic model_edge();
        logic [NS-1:0] am, np, sv;
        int best, bp;
        am = '0;
        if (reg_rd) m_rdata = exp_read(reg_addr, reg_size);
        if (ack && m_vld && EDGE_CFG[m_s]) am[m_s] = 1'b1;
        np = (m_pend & ~am & ~src_clr) | src_set;
        if (ack && m_vld) begin
            sv = m_pend & ~am;
            best = -1; bp = 0;
            for (int n = 0; n < NS; n++)
                if (sv[n] && int'(pri_of(n)) > bp) begin best = n; bp = int'(pri_of(n)); end
            m_vld = 1'b0; m_fast = 1'b0; m_p = '0; m_s = '0;
            if (best > 0 && m_en[best]) issue(best);
        end else if (m_vld) begin
            if (src_clr[m_s] && !EDGE_CFG[m_s] && !src_set[m_s]) begin
                m_vld = 1'b0; m_fast = 1'b0; m_p = '0; m_s = '0;
            end
        end else begin
            for (int n = 1; n < NS; n++)
                if (src_set[n] && m_en[n]) begin issue(n); break; end
        end
        m_pend = np;
        if (reg_wr) begin
            if (reg_addr == 8'hFE) begin
                if (reg_size) begin m_fast_on = reg_wdata[15]; m_fast_sel = reg_wdata[7:0]; end
            end else if (!reg_size) begin
                if (reg_addr < 8'd8) m_en[int'(reg_addr)*8 +: 8] = reg_wdata[7:0];
                else if (reg_addr >= 8'h40 && reg_addr < 8'h60)
                    m_pri[int'(reg_addr - 8'h40)] = reg_wdata[3:0];
            end
        end
    endtask

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_norm();
        return (m_vld && !m_fast) ? {m_p, m_s} : 12'h000;
    endfunction
    function automatic logic [11:0] exp_fast();
        return (m_vld && m_fast) ? {m_p, m_s} : 12'h000;
    endfunction

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "norm_req", {4'h0, norm_req}, {4'h0, exp_norm()});
        check(tag, "fast_req", {4'h0, fast_req}, {4'h0, exp_fast()});
        check(tag, "reg_rdata", reg_rdata, m_rdata);
        src_set = '0; src_clr = '0; ack = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_size = 1'b0;
    endtask

    task automatic wr(string tag, logic [7:0] a, logic s, logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        step(tag);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic s);
        reg_rd = 1'b1; reg_addr = a; reg_size = s;
        step(tag);
    endtask

    task automatic pulse_set(string tag, logic [NS-1:0] v);
        src_set = v;
        step(tag);
    endtask

    task automatic do_ack(string tag);
        ack = 1'b1;
        step(tag);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_pri[i] = '0;
        repeat (3) @(negedge clk);
        check("R1", "norm_req reset", {4'h0, norm_req}, 16'h0);
        check("R1", "fast_req reset", {4'h0, fast_req}, 16'h0);
        check("R1", "rdata reset", reg_rdata, 16'h0);
        rst_n = 1'b1;
        rd("R1", 8'h00, 1'b0);
        rd("R1", 8'h45, 1'b0);
        rd("R1", 8'hFE, 1'b1);

        // R2 / R4: source 10 = byte 1 bit 2, priority register 5
        wr("R2", 8'h01, 1'b0, 16'h0004);
        wr("R4", 8'h45, 1'b0, 16'h00F7);
        rd("R4", 8'h45, 1'b0);
        pulse_set("R2", 64'(1) << 9);
        pulse_set("R2", 64'(1) << 10);
        step("R4");
        do_ack("R6");
        step("R7");

        // R3: source 0 never issued, lowest of simultaneous sets wins
        wr("R3", 8'h00, 1'b0, 16'h00FF);
        pulse_set("R3", 64'(1));
        pulse_set("R3", (64'(1) << 3) | (64'(1) << 5));
        pulse_set("R3", 64'(1) << 6);
        step("R3");

        // R7: rescan by priority, tie goes to lower index
        wr("R7", 8'h41, 1'b0, 16'h0009); // sources 2,3
        wr("R7", 8'h42, 1'b0, 16'h0009); // sources 4,5
        wr("R7", 8'h43, 1'b0, 16'h0002); // sources 6,7
        do_ack("R7");
        do_ack("R7");
        do_ack("R7");
        do_ack("R6");

        // R5: fast routing for source 12 (level source)
        wr("R5", 8'h01, 1'b0, 16'h0014);          // sources 10 and 12 enabled
        wr("R5", 8'hFE, 1'b1, 16'hFF0C);
        rd("R5", 8'hFE, 1'b1);
        wr("R5", 8'h46, 1'b0, 16'h0003);
        pulse_set("R5", 64'(1) << 12);
        wr("R5", 8'hFE, 1'b1, 16'h000A);           // retarget while held
        step("R5");

        // R6: ack of level source keeps it pending -> re-picked
        do_ack("R6");
        do_ack("R6");
        // R9: withdraw held level source
        src_clr = 64'(1) << 12;
        step("R9");
        step("R9");
        pulse_set("R9", 64'(1) << 12);
        src_set = 64'(1) << 12; src_clr = 64'(1) << 12;
        step("R9");

        // R8: access-size rules
        rd("R8", 8'hFE, 1'b0);
        rd("R8", 8'h01, 1'b1);
        rd("R8", 8'h80, 1'b0);
        wr("R8", 8'h01, 1'b1, 16'h00FF);
        rd("R8", 8'h01, 1'b0);
        wr("R8", 8'hFE, 1'b0, 16'h8001);
        rd("R8", 8'hFE, 1'b1);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 8'h02; reg_wdata = 16'h0055;
        step("R8");
        rd("R8", 8'h02, 1'b0);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom_range(0, 15));
            if (r < 5) src_set[$urandom_range(0, NS-1)] = 1'b1;
            if (r == 6) begin
                src_set[$urandom_range(0, NS-1)] = 1'b1;
                src_set[$urandom_range(0, NS-1)] = 1'b1;
            end
            if ($urandom_range(0, 15) == 0) src_clr[$urandom_range(0, NS-1)] = 1'b1;
            if ($urandom_range(0, 2) == 0) ack = 1'b1;
            r = int'($urandom_range(0, 15));
            if (r < 2) begin
                reg_wr = 1'b1; reg_size = 1'b0;
                reg_addr = r == 0 ? 8'($urandom_range(0, 7)) : 8'($urandom_range(8'h40, 8'h5F));
                reg_wdata = 16'($urandom_range(0, 255));
            end else if (r == 2) begin
                reg_wr = 1'b1; reg_size = 1'($urandom_range(0, 1)); reg_addr = 8'hFE;
                reg_wdata = {1'($urandom_range(0, 1)), 7'h55, 8'($urandom_range(0, 63))};
            end else if (r < 5) begin
                reg_rd = 1'b1; reg_size = 1'($urandom_range(0, 1));
                reg_addr = 8'($urandom_range(0, 255));
            end
            step("R3/R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule